// File: doc/BRIEF.md
# Configurable SPI Master Serial Port

This block is a synchronous serial port that acts only as an SPI bus master. A host reaches it through a small word-wide register interface. A control word sets the per-bit clock count, the idle level of the serial clock, the capture edge, the frame format and the frame length. A separate prescale register sets the first stage of the bit clock divider. Words that the host writes to the data address go into an eight-entry transmit queue. The port sends them one frame at a time on the serial pins, with the most significant bit first. Each frame also captures a word from the input pin and places it in an eight-entry receive queue, which the host empties by reading the same data address.

The serial clock runs at the peripheral clock divided by the product of the prescale value and the per-bit count. The prescale value is even and lies from 2 to 254. The per-bit count is the rate field plus one. A frame carries from 4 to 16 bits. Each frame is framed by an active-low select line, which rises between frames. Only the SPI format code moves data. The other format codes and the three smallest size codes are refused, and the bus stays idle while they are selected.

Top module: `spi_master_port`

## Requirements
- R1: After reset the control word reads 0x0000, the prescale register reads 2, the status word reads 0x0003, the select output is high, and both the serial clock and the data output are low.
- R2: With prescale value P and rate field S, every half period of the serial clock lasts (P/2)*(S+1) clock cycles. A frame of N bits holds the select line low for (2N+1) half periods, starting at the first edge after the frame starts.
- R3: Control bit 6 sets the idle level of the serial clock: 0 idles low and 1 idles high. Outside a frame the clock sits at that level, and it returns to it after the last edge of each frame.
- R4: When control bit 7 is 0, the input pin is sampled on the odd clock edges of a frame and the output bit changes on the even edges. When control bit 7 is 1, the input is sampled on the even edges and the output bit changes on the odd edges after the first one.
- R5: The size field in control bits 3:0 gives a frame length of field+1 bits. Only the low field+1 bits of a transmit word are sent, most significant first. The received word is right-justified, with zero in the upper bits.
- R6: A frame starts only when the format field in control bits 5:4 is 00 and the size field is 3 or more. Under any other code the select line stays high, the serial clock holds its idle level, and queued transmit words stay in the queue.
- R7: A write to the prescale register stores bits 7:0 with bit 0 cleared. If the result is 0, the register holds 2 instead.
- R8: Each queue holds 8 words. A data write while the transmit queue is full is dropped. A data read while the receive queue is empty returns 0. A word received while the receive queue is full is discarded.
- R9: The status word has these bits: bit 0 is transmit queue empty, bit 1 is transmit queue not full, bit 2 is receive queue not empty, bit 3 is receive queue full, and bit 4 is busy. Busy is set while a frame or its trailing gap is in progress, or while the transmit queue holds a word.
- R10: Between two frames the select line stays high for 2 half periods plus one clock cycle. The serial clock never toggles while the select line is high.
- R11: The register offsets are 0x00 for control, 0x04 for a reserved second control word, 0x08 for data, 0x0C for status and 0x10 for prescale. Offset 0x04 always reads 0 and ignores writes. Writes to the status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read strobe, 0 otherwise |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out, low outside frames |
| spi_miso | input | 1 | Serial data in |
| spi_ssel_n | output | 1 | Active-low frame select |

## Verification
The assertions assume that the host changes the control and prescale registers only while the port is idle, that is, with no frame in progress and an empty transmit queue. The edge count and the idle-clock checks depend on that configuration staying constant for the whole frame. The stimulus meets this assumption by waiting for the reference model to report idle before every configuration write. It also issues receive-queue reads only when no frame can finish in the same cycle. Transmit writes never reach a full queue while a frame could start in the same cycle, except in the deliberate overflow case, where the format is reserved and no frame can start.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the SPI master port.
// Assumes a 16-bit host data path and a 5-bit byte offset address.
package spi_port_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int SIZE_W = 4;
    localparam int RATE_W = 8;
    localparam int PRE_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL2  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PRE    = 5'h10;

    localparam int ST_TX_EMPTY   = 0;
    localparam int ST_TX_ROOM    = 1;
    localparam int ST_RX_AVAIL   = 2;
    localparam int ST_RX_FULL    = 3;
    localparam int ST_BUSY       = 4;
    localparam int ST_W          = 5;

    localparam logic [1:0] FMT_SPI = 2'b00;
    localparam logic [SIZE_W-1:0] SIZE_MIN = 4'd3;

    // Control word layout: rate 15:8, phase 7, polarity 6, format 5:4, size 3:0.
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              phase;
        logic              polarity;
        logic [1:0]        fmt;
        logic [SIZE_W-1:0] size;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_TAIL  = 2'd2,
        ENG_GAP   = 2'd3
    } eng_state_t;

endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
// Module: spi_fifo
// A synchronous first-in first-out queue with a registered occupancy count.
// A push while full and a pop while empty are ignored. Push and pop may
// occur in the same cycle. The read port shows the oldest entry.
module spi_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_bitclk.sv
`timescale 1ns/1ps
// Module: spi_bitclk
// Two-stage divider that emits a one-cycle tick every half bit period.
// The first stage counts half_div cycles, and the second stage counts rate+1
// first-stage wraps. Both stages are held at zero while run is low, so the
// first tick comes exactly one half period after run rises.
// Assumes half_div is at least 1.
module spi_bitclk #(
    parameter int HALF_W = 7,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_div,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [HALF_W-1:0] pre_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic              pre_wrap;

    assign pre_wrap = (pre_cnt == HALF_W'(half_div - 1'b1));
    assign tick     = run && pre_wrap && (rate_cnt == rate);

    // Run the prescale stage and the per-bit stage, and clear both when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
// Module: spi_frame_engine
// Moves one word per frame between the queues and the serial pins.
// A frame opens by pulling the select line low and showing the first bit.
// It then makes 2N clock edges at half-period ticks, waits one more half
// period (tail), releases the select line, pushes the received word, and
// holds a gap of two half periods before it can start the next frame.
// Assumes the configuration inputs stay constant while busy is high.
// Polarity and phase are latched at the start of each frame.
module spi_frame_engine
    import spi_port_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_polarity,
    input  logic          cfg_phase,
    input  logic [1:0]    cfg_fmt,
    input  logic [SW-1:0] cfg_size,
    input  logic          tx_avail,
    input  logic [DW-1:0] tx_word,
    input  logic          tick,
    input  logic          miso,
    output logic          tx_take,
    output logic          rx_put,
    output logic [DW-1:0] rx_word,
    output logic          sck,
    output logic          mosi,
    output logic          ssel_n,
    output logic          busy
);
    localparam int EDGE_W = SW + 2;

    eng_state_t         state;
    logic [SW-1:0]      len_q;
    logic               pol_q, pha_q;
    logic [EDGE_W-1:0]  edge_cnt, edge_nxt, edge_last;
    logic [DW-1:0]      tx_sr, rx_sr, tx_aligned;
    logic               clk_phase, mosi_q, ssel_q, gap_half;
    logic               cfg_ok, start, odd_edge, do_sample, do_drive;

    assign cfg_ok     = (cfg_fmt == FMT_SPI) && (cfg_size >= SIZE_MIN);
    assign start      = (state == ENG_IDLE) && tx_avail && cfg_ok;
    assign tx_aligned = tx_word << (SW'(DW - 1) - cfg_size);
    assign edge_last  = {1'b0, len_q, 1'b0} + EDGE_W'(2);
    assign edge_nxt   = edge_cnt + 1'b1;
    assign odd_edge   = edge_nxt[0];
    assign do_sample  = (odd_edge != pha_q);
    assign do_drive   = !do_sample &&
                        (pha_q ? (edge_nxt != EDGE_W'(1)) : (edge_nxt != edge_last));

    assign tx_take = start;
    assign rx_put  = (state == ENG_TAIL) && tick;
    assign rx_word = rx_sr;
    assign busy    = (state != ENG_IDLE);
    assign sck     = (state == ENG_IDLE) ? cfg_polarity : (pol_q ^ clk_phase);
    assign mosi    = mosi_q;
    assign ssel_n  = ssel_q;

    // Frame sequencer: start, edge generation, tail and inter-frame gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            len_q     <= '0;
            pol_q     <= 1'b0;
            pha_q     <= 1'b0;
            edge_cnt  <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            clk_phase <= 1'b0;
            mosi_q    <= 1'b0;
            ssel_q    <= 1'b1;
            gap_half  <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state     <= ENG_SHIFT;
                        len_q     <= cfg_size;
                        pol_q     <= cfg_polarity;
                        pha_q     <= cfg_phase;
                        edge_cnt  <= '0;
                        clk_phase <= 1'b0;
                        rx_sr     <= '0;
                        mosi_q    <= tx_aligned[DW-1];
                        tx_sr     <= tx_aligned << 1;
                        ssel_q    <= 1'b0;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        edge_cnt  <= edge_nxt;
                        clk_phase <= ~clk_phase;
                        if (do_sample) begin
                            rx_sr <= {rx_sr[DW-2:0], miso};
                        end
                        if (do_drive) begin
                            mosi_q <= tx_sr[DW-1];
                            tx_sr  <= tx_sr << 1;
                        end
                        if (edge_nxt == edge_last) begin
                            state <= ENG_TAIL;
                        end
                    end
                end
                ENG_TAIL: begin
                    if (tick) begin
                        state    <= ENG_GAP;
                        ssel_q   <= 1'b1;
                        mosi_q   <= 1'b0;
                        gap_half <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= ENG_IDLE;
                        end
                        gap_half <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_master_port.sv
`timescale 1ns/1ps
// Module: spi_master_port
// Top level of the SPI master serial port. It holds the control and prescale
// registers, decodes host accesses, and joins the two queues, the bit clock
// divider and the frame engine. Read data is combinational from registered
// state. A data read pops the receive queue at the closing clock edge.
// Assumes at most one host access per cycle.
module spi_master_port
    import spi_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ssel_n
);
    localparam int HALF_W = PRE_W - 1;

    ctrl_word_t        ctrl_q;
    logic [PRE_W-1:0]  pre_q, pre_in;
    logic              wr_ctrl, wr_pre, tx_push, rx_pop;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_take, rx_put, tick, engine_busy;
    logic [ST_W-1:0]   status;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_pre  = bus_sel && bus_wr && (bus_addr == OFS_PRE);
    assign tx_push = bus_sel && bus_wr && (bus_addr == OFS_DATA);
    assign rx_pop  = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
    assign pre_in  = {bus_wdata[PRE_W-1:1], 1'b0};

    // Control and prescale registers with prescale normalisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pre_q  <= PRE_W'(2);
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_word_t'(bus_wdata);
            end
            if (wr_pre) begin
                pre_q <= (pre_in == '0) ? PRE_W'(2) : pre_in;
            end
        end
    end

    spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .pop   (tx_take),
        .wdata (bus_wdata),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_put),
        .pop   (rx_pop),
        .wdata (rx_word),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_bitclk #(.HALF_W(HALF_W), .RATE_W(RATE_W)) bitclk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (engine_busy),
        .half_div (pre_q[PRE_W-1:1]),
        .rate     (ctrl_q.rate),
        .tick     (tick)
    );

    spi_frame_engine #(.DW(DATA_W), .SW(SIZE_W)) engine_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_polarity (ctrl_q.polarity),
        .cfg_phase    (ctrl_q.phase),
        .cfg_fmt      (ctrl_q.fmt),
        .cfg_size     (ctrl_q.size),
        .tx_avail     (!tx_empty),
        .tx_word      (tx_head),
        .tick         (tick),
        .miso         (spi_miso),
        .tx_take      (tx_take),
        .rx_put       (rx_put),
        .rx_word      (rx_word),
        .sck          (spi_sck),
        .mosi         (spi_mosi),
        .ssel_n       (spi_ssel_n),
        .busy         (engine_busy)
    );

    // Assemble the status word from queue flags and engine activity.
    always_comb begin
        status               = '0;
        status[ST_TX_EMPTY]  = tx_empty;
        status[ST_TX_ROOM]   = !tx_full;
        status[ST_RX_AVAIL]  = !rx_empty;
        status[ST_RX_FULL]   = rx_full;
        status[ST_BUSY]      = engine_busy || !tx_empty;
    end

    // Read multiplexer, which returns zero outside a read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata = ctrl_q;
                OFS_DATA:   bus_rdata = rx_empty ? '0 : rx_head;
                OFS_STATUS: bus_rdata = DATA_W'(status);
                OFS_PRE:    bus_rdata = DATA_W'(pre_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_master_port_chk.sv
`timescale 1ns/1ps
// Module: spi_master_port_chk
// Assertion checker bound to spi_master_port. Assumes the configuration is
// changed only while the port is idle.
module spi_master_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       ssel_n,
    input logic       cpol,
    input logic [1:0] fmt,
    input logic [3:0] size,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       tx_push,
    input logic       tx_take,
    input logic       rx_full,
    input logic       rx_empty,
    input logic       engine_busy
);
    logic       sck_d;
    logic [5:0] toggles;

    // Count serial clock toggles while the select line is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            toggles <= '0;
        end else begin
            sck_d <= sck;
            if (ssel_n) begin
                toggles <= '0;
            end else if (sck != sck_d) begin
                toggles <= toggles + 1'b1;
            end
        end
    end

    // R5
    edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssel_n) |-> (toggles == ({2'b00, size} + 6'd1) * 6'd2));

    // R10
    quiet_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && ssel_n) |-> !$stable(cpol));

    // R6
    blocked_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssel_n && !engine_busy && ((fmt != 2'b00) || (size < 4'd3))) |=> ssel_n);

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_take) |=> tx_full);

    // R9
    tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_full, tx_empty}));

    // R9
    rx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_full, rx_empty}));

endmodule

bind spi_master_port spi_master_port_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (spi_sck),
    .ssel_n      (spi_ssel_n),
    .cpol        (ctrl_q.polarity),
    .fmt         (ctrl_q.fmt),
    .size        (ctrl_q.size),
    .tx_full     (tx_full),
    .tx_empty    (tx_empty),
    .tx_push     (tx_push),
    .tx_take     (tx_take),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .engine_busy (engine_busy)
);

// File: tb/spi_master_port_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference (queues and timed loops) that predicts the
// serial pins on every clock and the register contents on each read.
module spi_master_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_ssel_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    logic [15:0] m_ctrl = '0;
    int          m_pre = 2;
    logic        m_active = 1'b0;
    logic        e_sck = 1'b0, e_mosi = 1'b0, e_ssel = 1'b1;
    logic [15:0] lfsr = 16'hACE1;

    spi_master_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .spi_ssel_n (spi_ssel_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d, output logic [15:0] exp_data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        exp_data = (rxq.size() > 0) ? rxq[0] : 16'h0000;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    function automatic logic [15:0] model_status();
        logic [15:0] s = '0;
        s[0] = (txq.size() == 0);
        s[1] = (txq.size() < 8);
        s[2] = (rxq.size() > 0);
        s[3] = (rxq.size() == 8);
        s[4] = m_active || (txq.size() > 0);
        return s;
    endfunction

    task automatic wait_idle();
        do @(negedge clk); while (m_active || txq.size() > 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic drain_rx(input string tag, input int n);
        logic [15:0] d, e;
        for (int i = 0; i < n; i++) begin
            bus_read(5'h08, d, e);
            check_eq(tag, d, e);
        end
    endtask

    // Host-side model: register writes, queue pushes and pops.
    always @(posedge clk) begin
        if (rst_n && bus_sel) begin
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_ctrl = bus_wdata;
                    5'h08: if (txq.size() < 8) txq.push_back(bus_wdata);
                    5'h10: m_pre = ((bus_wdata[7:0] & 8'hFE) == 0) ? 2 : int'(bus_wdata[7:0] & 8'hFE);
                    default: ;
                endcase
            end else if (bus_addr == 5'h08 && rxq.size() > 0) begin
                void'(rxq.pop_front());
            end
        end
    end

    // Serial input source: a pseudo-random bit stream that changes on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            spi_miso = lfsr[0];
        end
    end

    // Frame timeline model.
    initial begin : ref_frames
        logic [15:0] w, rxw;
        int n, h;
        logic cp, ph;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txq.size() > 0 && m_ctrl[5:4] == 2'b00 && m_ctrl[3:0] >= 4'd3) begin
                @(posedge clk);
                w = txq.pop_front();
                n = int'(m_ctrl[3:0]) + 1;
                cp = m_ctrl[6];
                ph = m_ctrl[7];
                h = (m_pre / 2) * (int'(m_ctrl[15:8]) + 1);
                rxw = '0;
                #1;
                m_active = 1'b1; e_ssel = 1'b0; e_mosi = w[n-1]; e_sck = cp;
                for (int e = 1; e <= 2 * n; e++) begin
                    repeat (h) @(posedge clk);
                    if (((e % 2) == 1) != ph) rxw = {rxw[14:0], spi_miso};
                    #1 e_sck = ~e_sck;
                    if (ph && (e % 2) == 1 && e > 1) e_mosi = w[n - 1 - (e - 1) / 2];
                    if (!ph && (e % 2) == 0 && e < 2 * n) e_mosi = w[n - 1 - e / 2];
                end
                repeat (h) @(posedge clk);
                if (rxq.size() < 8) rxq.push_back(rxw);
                #1 e_ssel = 1'b1; e_mosi = 1'b0;
                repeat (2 * h) @(posedge clk);
                #1 m_active = 1'b0;
            end
        end
    end

    // Compare the serial pins with the model on every clock (R2 R3 R4 R5 R6 R10).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                check_eq("R2 R3 R4 R10 sck", {15'd0, spi_sck}, {15'd0, m_active ? e_sck : m_ctrl[6]});
                check_eq("R5 R6 R10 ssel", {15'd0, spi_ssel_n}, {15'd0, m_active ? e_ssel : 1'b1});
                check_eq("R4 R5 mosi", {15'd0, spi_mosi}, {15'd0, m_active ? e_mosi : 1'b0});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus
    initial begin : stim
        logic [15:0] d, e;
        int lo, hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R11 map
        bus_read(5'h00, d, e); check_eq("R1 ctrl reset", d, 16'h0000);
        bus_read(5'h10, d, e); check_eq("R1 prescale reset", d, 16'h0002);
        bus_read(5'h0C, d, e); check_eq("R1 status reset", d, 16'h0003);
        check_eq("R1 pins reset", {13'd0, spi_ssel_n, spi_sck, spi_mosi}, 16'h0004);
        bus_write(5'h04, 16'hFFFF);
        bus_read(5'h04, d, e); check_eq("R11 ctrl2 reads zero", d, 16'h0000);
        bus_write(5'h0C, 16'hFFFF);
        bus_read(5'h0C, d, e); check_eq("R11 status read-only", d, 16'h0003);

        // R7 prescale normalisation
        bus_write(5'h10, 16'h0001); bus_read(5'h10, d, e); check_eq("R7 prescale 1", d, 16'h0002);
        bus_write(5'h10, 16'h0007); bus_read(5'h10, d, e); check_eq("R7 prescale 7", d, 16'h0006);
        bus_write(5'h10, 16'hFF00); bus_read(5'h10, d, e); check_eq("R7 prescale 0", d, 16'h0002);

        // R6 reserved size and format codes hold the bus idle
        bus_write(5'h00, 16'h0002);
        bus_write(5'h08, 16'h00A5);
        repeat (40) @(negedge clk);
        bus_read(5'h0C, d, e); check_eq("R6 R9 size code 2 blocked", d, 16'h0012);
        bus_write(5'h00, 16'h0017);
        repeat (40) @(negedge clk);
        bus_write(5'h00, 16'h0037);
        repeat (40) @(negedge clk);
        bus_write(5'h00, 16'h0027);
        repeat (40) @(negedge clk);
        bus_read(5'h0C, d, e); check_eq("R6 format codes blocked", d, 16'h0012);

        // R8 transmit overflow drops a write
        for (int i = 0; i < 8; i++) bus_write(5'h08, 16'h1100 + 16'(i * 37));
        bus_read(5'h0C, d, e); check_eq("R8 R9 tx full", d, 16'h0010);

        // Release: SPI, 8 bits, polarity 0, phase 0
        bus_write(5'h00, 16'h0007);
        wait_idle();
        bus_read(5'h0C, d, e); check_eq("R8 R9 rx full after 8 frames", d, model_status());
        check_eq("R9 status value", d, 16'h000F);
        drain_rx("R5 R8 rx data mode 0", 8);
        bus_read(5'h08, d, e); check_eq("R8 empty read zero", d, 16'h0000);

        // R3 R4 polarity 1 phase 1, 16 bits, rate 2, prescale 6
        bus_write(5'h10, 16'h0006);
        bus_write(5'h00, 16'h02CF);
        bus_write(5'h08, 16'hBEEF); bus_write(5'h08, 16'h1234);
        wait_idle();
        drain_rx("R3 R4 R5 rx data mode 3", 2);

        // R4 R5 polarity 0 phase 1, 4 bits, only low bits sent
        bus_write(5'h10, 16'h0002);
        bus_write(5'h00, 16'h0183);
        bus_write(5'h08, 16'hFFF5); bus_write(5'h08, 16'h000A);
        wait_idle();
        drain_rx("R4 R5 rx data 4-bit", 2);

        // R3 R4 polarity 1 phase 0, 12 bits, prescale 4
        bus_write(5'h10, 16'h0004);
        bus_write(5'h00, 16'h004B);
        bus_write(5'h08, 16'h0C3A); bus_write(5'h08, 16'hF5A5);
        wait_idle();
        drain_rx("R3 R4 R5 rx data 12-bit", 2);

        // R2 R10 timing: 16 bits, rate 3, prescale 2, half period 4
        bus_write(5'h10, 16'h0002);
        bus_write(5'h00, 16'h0000);
        bus_write(5'h08, 16'h8001); bus_write(5'h08, 16'h7FFE);
        bus_write(5'h00, 16'h030F);
        lo = 0; hi = 0;
        do @(negedge clk); while (spi_ssel_n);
        while (!spi_ssel_n) begin lo++; @(negedge clk); end
        while (spi_ssel_n) begin hi++; @(negedge clk); end
        check_eq("R2 select low span", 16'(lo), 16'd132);
        check_eq("R10 select gap span", 16'(hi), 16'd9);
        wait_idle();
        drain_rx("R5 rx data timing run", 2);

        // R8 receive overflow: ninth word is discarded
        bus_write(5'h00, 16'h0007);
        for (int i = 0; i < 9; i++) bus_write(5'h08, 16'h0040 + 16'(i * 3));
        wait_idle();
        bus_read(5'h0C, d, e); check_eq("R8 R9 rx full", d, 16'h000F);
        drain_rx("R8 rx overflow contents", 8);
        bus_read(5'h0C, d, e); check_eq("R8 R9 rx drained", d, 16'h0003);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule